// File: doc/BRIEF.md
# Four-channel cycle-steal DMA controller

The block moves data on behalf of four independent channels over a single-beat memory bus. Each channel is set up with a source address, a destination address, a transfer count, a count reload value and a control word. The control word selects an 8-bit or 16-bit transfer unit and which address advances: the source advances and the destination stays put, or the reverse. A two-bit mode code either turns the channel off, arms it for a fixed number of transfers, or arms it to run over and over.

Every request, from a per-channel request input or from a software trigger bit in the control word, is latched. When the bus engine is idle, a fixed-priority arbiter grants the lowest-numbered channel that has a request and is eligible. The engine then steals the bus for exactly one transfer. It reads the source, writes the data to the destination, and updates that channel's addresses and counter. When a transfer takes a channel's counter from 0001h to 0000h, the channel raises a one-cycle interrupt pulse. Every channel register can be read and written at any time through a small register port.

Top module: `dma_steal4`

## Requirements
- R1: When several eligible channels have pending requests and the engine is idle, the lowest-numbered channel is served first.
- R2: A transfer is a read of the source address followed by a write of the read data to the destination address. Each phase holds bus_req, bus_we and bus_addr until bus_rdy. bus_size is 1 for a 16-bit unit (control bit 0 = 1) and 0 for an 8-bit unit, which writes only the low byte of the read data, zero-extended.
- R3: Control bit 1 picks the direction. 0 advances the source and keeps the destination fixed. 1 keeps the source fixed and advances the destination. The step is 2 for a 16-bit unit and 1 for an 8-bit unit.
- R4: Mode code 01 (control bits 3:2) is single mode. Each transfer lowers the counter by one. While the counter is 0000h no transfer occurs, and requests are discarded.
- R5: Mode code 11 is repeat mode. A transfer that would leave the counter at 0000h, or that starts from 0000h, loads the counter from the reload register instead, and the channel stays armed.
- R6: irq[i] is high for exactly one cycle, the second cycle after the write phase completes, when a transfer on channel i found its counter at 0001h.
- R7: Mode codes 00 and 10 disable the channel. Requests made while it is disabled cause no transfer and do not survive until a later enable.
- R8: A request from dreq[i], or from writing the control word with bit 4 set, is held until served. A request that arrives while another channel is on the bus is served afterwards.
- R9: After reset all registers read 0000h and the bus is idle. Each register reads back the last value written to it or as updated by transfers. The register address is {channel, select}, where select is 0 source, 1 destination, 2 counter, 3 reload, 4 control.
- R10: A control write to a channel while its own transfer is on the bus updates the mode only after that transfer completes. The transfer still updates the counter under the old mode.
- R11: Between the completion of one write phase and the next read phase, bus_req is low for at least two cycles, so every transfer takes at least four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | {channel, register select} |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data for reg_addr |
| dreq | input | 4 | Per-channel request pulses |
| irq | output | 4 | Per-channel terminal count pulses |
| bus_req | output | 1 | Bus phase active |
| bus_we | output | 1 | 1 write phase, 0 read phase |
| bus_size | output | 1 | 1 for 16-bit unit, 0 for 8-bit |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_rdy | input | 1 | Phase completes on this cycle |

## Verification
A wrong counter or mode state shows up at the ports within one request. It appears as a transfer that should not occur, as a missing transfer, or as an interrupt pulse on the wrong transfer, and the next register readback exposes the stale count. An address register that steps wrongly shows on bus_addr in the very next transfer of that channel. A lost or misordered latched request shows as a wrong channel order in the address stream once the current transfer ends.

// File: rtl/dmas_pkg.sv
`timescale 1ns/1ps
package dmas_pkg;
   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_READ  = 2'd1,
      ENG_WRITE = 2'd2,
      ENG_DONE  = 2'd3
   } eng_state_t;

   localparam logic [1:0] MODE_OFF  = 2'b00;
   localparam logic [1:0] MODE_ONCE = 2'b01;
   localparam logic [1:0] MODE_LOOP = 2'b11;

   localparam logic [2:0] SEL_SRC = 3'd0;
   localparam logic [2:0] SEL_DST = 3'd1;
   localparam logic [2:0] SEL_CNT = 3'd2;
   localparam logic [2:0] SEL_RLD = 3'd3;
   localparam logic [2:0] SEL_CTL = 3'd4;

   localparam int CTL_UNIT = 0;
   localparam int CTL_DIR  = 1;
   localparam int CTL_MLO  = 2;
   localparam int CTL_MHI  = 3;
   localparam int CTL_TRIG = 4;
endpackage

// File: rtl/dmas_chan.sv
`timescale 1ns/1ps
module dmas_chan
   import dmas_pkg::*;
#(
   parameter int AW = 24,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_sel,
   input  logic [AW-1:0] wr_data,
   input  logic [2:0]    rd_sel,
   output logic [AW-1:0] rd_data,
   input  logic          dreq,
   input  logic          take,
   input  logic          done,
   input  logic          busy,
   output logic [AW-1:0] src_o,
   output logic [AW-1:0] dst_o,
   output logic          unit_o,
   output logic          ready_o,
   output logic          irq_o
);
   logic [AW-1:0] src_q, dst_q;
   logic [CW-1:0] cnt_q, rld_q, cnt_nx;
   logic          unit_q, dir_q, pend_q, irq_q, mode_hold;
   logic [1:0]    mode_q, mode_nx;
   logic          elig;
   logic [AW-1:0] step;
   logic          wr_src, wr_dst, wr_cnt, wr_rld, wr_ctl, trig;

   assign elig   = ((mode_q == MODE_ONCE) && (cnt_q != '0)) || (mode_q == MODE_LOOP);
   assign step   = unit_q ? AW'(2) : AW'(1);
   assign wr_src = wr_en && (wr_sel == SEL_SRC);
   assign wr_dst = wr_en && (wr_sel == SEL_DST);
   assign wr_cnt = wr_en && (wr_sel == SEL_CNT);
   assign wr_rld = wr_en && (wr_sel == SEL_RLD);
   assign wr_ctl = wr_en && (wr_sel == SEL_CTL);
   assign trig   = wr_ctl && wr_data[CTL_TRIG];

   always_comb begin
      if (mode_q == MODE_LOOP) begin
         cnt_nx = (cnt_q <= CW'(1)) ? rld_q : cnt_q - CW'(1);
      end else begin
         cnt_nx = (cnt_q == '0) ? '0 : cnt_q - CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q     <= '0;
         dst_q     <= '0;
         cnt_q     <= '0;
         rld_q     <= '0;
         unit_q    <= 1'b0;
         dir_q     <= 1'b0;
         mode_q    <= MODE_OFF;
         mode_nx   <= MODE_OFF;
         mode_hold <= 1'b0;
         pend_q    <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         irq_q  <= done && (cnt_q == CW'(1));
         pend_q <= (pend_q & ~take & elig) | dreq | trig;
         if (done) begin
            if (!dir_q) src_q <= src_q + step;
            else        dst_q <= dst_q + step;
            cnt_q <= cnt_nx;
            if (mode_hold) begin
               mode_q    <= mode_nx;
               mode_hold <= 1'b0;
            end
         end
         if (wr_src) src_q <= wr_data;
         if (wr_dst) dst_q <= wr_data;
         if (wr_cnt) cnt_q <= wr_data[CW-1:0];
         if (wr_rld) rld_q <= wr_data[CW-1:0];
         if (wr_ctl) begin
            unit_q <= wr_data[CTL_UNIT];
            dir_q  <= wr_data[CTL_DIR];
            if (busy) begin
               mode_nx   <= wr_data[CTL_MHI:CTL_MLO];
               mode_hold <= 1'b1;
            end else begin
               mode_q    <= wr_data[CTL_MHI:CTL_MLO];
               mode_hold <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      case (rd_sel)
         SEL_SRC: rd_data = src_q;
         SEL_DST: rd_data = dst_q;
         SEL_CNT: rd_data = {{(AW-CW){1'b0}}, cnt_q};
         SEL_RLD: rd_data = {{(AW-CW){1'b0}}, rld_q};
         SEL_CTL: rd_data = {{(AW-4){1'b0}}, mode_q, dir_q, unit_q};
         default: rd_data = '0;
      endcase
   end

   assign src_o   = src_q;
   assign dst_o   = dst_q;
   assign unit_o  = unit_q;
   assign ready_o = pend_q & elig;
   assign irq_o   = irq_q;

   // R6: an interrupt pulse only follows a completed transfer of this channel
   assert_irq_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(done));

   // R3: the fixed side keeps its address across a transfer
   assert_dst_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !dir_q && !wr_en) |=> $stable(dst_q));
   assert_src_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && dir_q && !wr_en) |=> $stable(src_q));

   // R4: single mode counts down by one per transfer
   assert_single_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (mode_q == MODE_ONCE) && (cnt_q != '0) && !wr_en)
      |=> (cnt_q == $past(cnt_q) - CW'(1)));

   // R5: repeat mode never parks at zero while the reload value is nonzero
   assert_loop_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (mode_q == MODE_LOOP) && (rld_q != '0) && !wr_en) |=> (cnt_q != '0));
endmodule

// File: rtl/dmas_arb.sv
`timescale 1ns/1ps
module dmas_arb #(
   parameter  int NCH = 4,
   localparam int IW  = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] req_i,
   output logic [NCH-1:0] gnt_o,
   output logic [IW-1:0]  idx_o,
   output logic           any_o
);
   logic [NCH:0] blk;
   assign blk[0] = 1'b0;

   for (genvar i = 0; i < NCH; i++) begin : g_pri
      assign gnt_o[i]  = req_i[i] & ~blk[i];
      assign blk[i+1]  = blk[i] | req_i[i];
   end

   assign any_o = blk[NCH];

   always_comb begin
      idx_o = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IW'(i);
      end
   end

   // R1: at most one grant, always to a requester, and never none while any request
   assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));
   assert_grant_subset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o & ~req_i) == '0);
   assert_grant_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i != '0) |-> (gnt_o != '0));
   assert_grant_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[0] |-> gnt_o[0]);
endmodule

// File: rtl/dmas_eng.sv
`timescale 1ns/1ps
module dmas_eng
   import dmas_pkg::*;
#(
   parameter  int NCH = 4,
   parameter  int AW  = 24,
   parameter  int BW  = 8,
   localparam int IW  = $clog2(NCH),
   localparam int DW  = 2 * BW
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    any_i,
   input  logic [IW-1:0]           idx_i,
   input  logic [NCH-1:0][AW-1:0]  src_i,
   input  logic [NCH-1:0][AW-1:0]  dst_i,
   input  logic [NCH-1:0]          unit_i,
   output logic                    take_o,
   output logic                    done_o,
   output logic                    busy_o,
   output logic [IW-1:0]           act_o,
   output logic                    bus_req,
   output logic                    bus_we,
   output logic                    bus_size,
   output logic [AW-1:0]           bus_addr,
   output logic [DW-1:0]           bus_wdata,
   input  logic [DW-1:0]           bus_rdata,
   input  logic                    bus_rdy
);
   eng_state_t    state_q;
   logic [IW-1:0] act_q;
   logic [AW-1:0] a_src, a_dst;
   logic          a_unit;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         act_q   <= '0;
         a_src   <= '0;
         a_dst   <= '0;
         a_unit  <= 1'b0;
         data_q  <= '0;
      end else begin
         case (state_q)
            ENG_IDLE: begin
               if (any_i) begin
                  act_q   <= idx_i;
                  a_src   <= src_i[idx_i];
                  a_dst   <= dst_i[idx_i];
                  a_unit  <= unit_i[idx_i];
                  state_q <= ENG_READ;
               end
            end
            ENG_READ: begin
               if (bus_rdy) begin
                  data_q  <= a_unit ? bus_rdata : {{BW{1'b0}}, bus_rdata[BW-1:0]};
                  state_q <= ENG_WRITE;
               end
            end
            ENG_WRITE: begin
               if (bus_rdy) state_q <= ENG_DONE;
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   assign take_o    = (state_q == ENG_IDLE) && any_i;
   assign done_o    = (state_q == ENG_DONE);
   assign busy_o    = (state_q != ENG_IDLE);
   assign act_o     = act_q;
   assign bus_req   = (state_q == ENG_READ) || (state_q == ENG_WRITE);
   assign bus_we    = (state_q == ENG_WRITE);
   assign bus_size  = a_unit;
   assign bus_addr  = (state_q == ENG_WRITE) ? a_dst : a_src;
   assign bus_wdata = data_q;

   // R2: every transfer opens with a read phase
   assert_read_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> !bus_we);
   // R2: a phase holds until ready
   assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
   // R2: a completed read is followed at once by the write phase
   assert_write_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_rdy) |=> (bus_req && bus_we));
   // R11: the bus is released for at least two cycles between transfers
   assert_bus_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req) |=> !bus_req);
endmodule

// File: rtl/dma_steal4.sv
`timescale 1ns/1ps
module dma_steal4
   import dmas_pkg::*;
#(
   parameter  int NCH = 4,
   parameter  int AW  = 24,
   parameter  int CW  = 16,
   parameter  int BW  = 8,
   localparam int IW  = $clog2(NCH),
   localparam int DW  = 2 * BW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_wr,
   input  logic [IW+2:0]  reg_addr,
   input  logic [AW-1:0]  reg_wdata,
   output logic [AW-1:0]  reg_rdata,
   input  logic [NCH-1:0] dreq,
   output logic [NCH-1:0] irq,
   output logic           bus_req,
   output logic           bus_we,
   output logic           bus_size,
   output logic [AW-1:0]  bus_addr,
   output logic [DW-1:0]  bus_wdata,
   input  logic [DW-1:0]  bus_rdata,
   input  logic           bus_rdy
);
   if (NCH < 2) begin : g_chk_nch
      $error("dma_steal4: NCH must be at least 2");
   end
   if (AW <= CW) begin : g_chk_aw
      $error("dma_steal4: AW must exceed CW");
   end
   if (CW < 2) begin : g_chk_cw
      $error("dma_steal4: CW must be at least 2");
   end

   logic [IW-1:0]          reg_ch;
   logic [NCH-1:0][AW-1:0] src_all, dst_all, rd_all;
   logic [NCH-1:0]         unit_all, ready_all, gnt;
   logic [IW-1:0]          gnt_idx, act;
   logic                   any, take, done, busy;

   assign reg_ch = reg_addr[IW+2:3];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic mine;
      assign mine = (act == IW'(i));
      dmas_chan #(.AW(AW), .CW(CW)) chan_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_wr && (reg_ch == IW'(i))),
         .wr_sel  (reg_addr[2:0]),
         .wr_data (reg_wdata),
         .rd_sel  (reg_addr[2:0]),
         .rd_data (rd_all[i]),
         .dreq    (dreq[i]),
         .take    (take && gnt[i]),
         .done    (done && mine),
         .busy    (busy && mine && !done),
         .src_o   (src_all[i]),
         .dst_o   (dst_all[i]),
         .unit_o  (unit_all[i]),
         .ready_o (ready_all[i]),
         .irq_o   (irq[i])
      );
   end

   assign reg_rdata = (int'(reg_ch) < NCH) ? rd_all[reg_ch] : '0;

   dmas_arb #(.NCH(NCH)) arb_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (ready_all),
      .gnt_o (gnt),
      .idx_o (gnt_idx),
      .any_o (any)
   );

   dmas_eng #(.NCH(NCH), .AW(AW), .BW(BW)) eng_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_i     (any),
      .idx_i     (gnt_idx),
      .src_i     (src_all),
      .dst_i     (dst_all),
      .unit_i    (unit_all),
      .take_o    (take),
      .done_o    (done),
      .busy_o    (busy),
      .act_o     (act),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_size  (bus_size),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_rdy   (bus_rdy)
   );

   // R6: interrupt pulses last one cycle
   assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq != '0) |=> (irq & $past(irq)) == '0);
endmodule

// File: tb/dma_steal4_tb_top.sv
`timescale 1ns/1ps
module dma_steal4_tb_top;
   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [23:0] reg_wdata = '0;
   logic [23:0] reg_rdata;
   logic [3:0]  dreq = '0;
   logic [3:0]  irq;
   logic        bus_req, bus_we, bus_size;
   logic [23:0] bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic        bus_rdy = 1'b0;

   always #2.5 clk = ~clk;

   dma_steal4 dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .irq(irq),
      .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk_eq(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] memf(logic [23:0] a);
      return a[15:0] ^ {a[7:0], a[23:16]} ^ 16'hA5C3;
   endfunction

   assign bus_rdata = memf(bus_addr);

   // bus slave and transfer log
   int          lat = 0;
   bit          slow = 0;
   int          tr_n = 0;
   logic [23:0] tr_src [1024];
   logic [23:0] tr_dst [1024];
   logic        tr_sz  [1024];
   logic [23:0] last_ra = '0;
   int          low_cnt = 0;
   bit          seen_xfer = 0;
   bit          prev_req = 0;
   int          irq_n [NCH];

   initial for (int i = 0; i < NCH; i++) irq_n[i] = 0;

   always @(negedge clk) begin
      for (int i = 0; i < NCH; i++) if (irq[i]) irq_n[i]++;
      if (bus_req && !prev_req && seen_xfer) chk_eq("R11 bus gap", (low_cnt >= 2), 1);
      if (!bus_req) low_cnt++;
      else low_cnt = 0;
      prev_req = bus_req;
      if (bus_req) begin
         if (lat <= 0) begin
            bus_rdy = 1'b1;
            if (!bus_we) last_ra = bus_addr;
            else begin
               chk_eq("R2 write data", bus_wdata,
                      bus_size ? memf(last_ra) : {8'h00, memf(last_ra) [7:0]});
               if (tr_n < 1024) begin
                  tr_src[tr_n] = last_ra;
                  tr_dst[tr_n] = bus_addr;
                  tr_sz[tr_n]  = bus_size;
               end
               tr_n++;
               seen_xfer = 1;
            end
            lat = slow ? 6 : int'($urandom_range(0, 2));
         end else begin
            bus_rdy = 1'b0;
            lat--;
         end
      end else begin
         bus_rdy = 1'b0;
      end
   end

   // expected channel state
   logic [23:0] e_src [NCH];
   logic [23:0] e_dst [NCH];
   logic [15:0] e_cnt [NCH];
   logic [15:0] e_rld [NCH];
   logic [3:0]  e_ctl [NCH];

   function automatic bit e_elig(int ch);
      return ((e_ctl[ch][3:2] == 2'b01) && (e_cnt[ch] != 0)) || (e_ctl[ch][3:2] == 2'b11);
   endfunction

   task automatic apply_xfer(int ch);
      logic [23:0] stp;
      stp = e_ctl[ch][0] ? 24'd2 : 24'd1;
      if (!e_ctl[ch][1]) e_src[ch] = e_src[ch] + stp;
      else               e_dst[ch] = e_dst[ch] + stp;
      if (e_ctl[ch][3:2] == 2'b11) e_cnt[ch] = (e_cnt[ch] <= 1) ? e_rld[ch] : e_cnt[ch] - 1;
      else                          e_cnt[ch] = e_cnt[ch] - 1;
   endtask

   task automatic wr_reg(int ch, int sel, logic [23:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_addr = {2'(ch), 3'(sel)};
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(int ch, int sel, output logic [23:0] d);
      @(negedge clk);
      reg_addr = {2'(ch), 3'(sel)};
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(logic [3:0] m);
      @(negedge clk);
      dreq = m;
      @(negedge clk);
      dreq = '0;
   endtask

   task automatic wait_idle();
      int quiet = 0;
      int guard = 0;
      while (quiet < 8 && guard < 5000) begin
         @(negedge clk);
         if (bus_req) quiet = 0;
         else quiet++;
         guard++;
      end
   endtask

   task automatic wait_busy();
      int guard = 0;
      while (!bus_req && guard < 200) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic set_ch(int ch, logic [23:0] s, logic [23:0] d, logic [15:0] c,
                         logic [15:0] r, logic [3:0] ctl);
      wr_reg(ch, 0, s);
      wr_reg(ch, 1, d);
      wr_reg(ch, 2, {8'h00, c});
      wr_reg(ch, 3, {8'h00, r});
      wr_reg(ch, 4, {20'h0, ctl});
      e_src[ch] = s; e_dst[ch] = d; e_cnt[ch] = c; e_rld[ch] = r; e_ctl[ch] = ctl;
   endtask

   task automatic check_regs(int ch, string tag);
      logic [23:0] v;
      rd_reg(ch, 0, v); chk_eq({tag, " R9 src readback"}, v, e_src[ch]);
      rd_reg(ch, 1, v); chk_eq({tag, " R9 dst readback"}, v, e_dst[ch]);
      rd_reg(ch, 2, v); chk_eq({tag, " R9 cnt readback"}, v, e_cnt[ch]);
      rd_reg(ch, 3, v); chk_eq({tag, " R9 rld readback"}, v, e_rld[ch]);
      rd_reg(ch, 4, v); chk_eq({tag, " R9 ctl readback"}, v, e_ctl[ch]);
   endtask

   // one request, expected outcome from the model
   task automatic run_req(int ch, bit sw, string tag);
      int t0, i0;
      bit el, ei;
      logic [23:0] xs, xd;
      t0 = tr_n; i0 = irq_n[ch];
      el = e_elig(ch);
      ei = el && (e_cnt[ch] == 1);
      xs = e_src[ch]; xd = e_dst[ch];
      if (sw) wr_reg(ch, 4, {19'h0, 1'b1, e_ctl[ch]});
      else    pulse(4'(1 << ch));
      wait_idle();
      chk_eq({tag, " R4 R7 transfer count"}, tr_n - t0, el ? 1 : 0);
      if (el && tr_n == t0 + 1) begin
         chk_eq({tag, " R2 source addr"}, tr_src[t0], xs);
         chk_eq({tag, " R2 dest addr"}, tr_dst[t0], xd);
         chk_eq({tag, " R2 size"}, tr_sz[t0], e_ctl[ch][0]);
         apply_xfer(ch);
      end
      chk_eq({tag, " R6 irq count"}, irq_n[ch] - i0, ei ? 1 : 0);
      check_regs(ch, tag);
   endtask

   initial begin
      logic [23:0] v;
      int t0;
      void'($urandom(32'd7151));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk_eq("R9 reset bus_req", bus_req, 0);
      chk_eq("R9 reset irq", irq, 0);
      for (int c = 0; c < NCH; c++) begin
         for (int s = 0; s < 5; s++) begin
            rd_reg(c, s, v);
            chk_eq("R9 reset register", v, 0);
         end
      end

      // single mode, 16-bit, source advances
      set_ch(2, 24'h800100, 24'hA08000, 16'd3, 16'd0, 4'h5);
      run_req(2, 0, "R3 R4 single 1");
      run_req(2, 0, "R4 single 2");
      run_req(2, 0, "R6 single last");
      run_req(2, 0, "R4 single at zero");

      // repeat mode, 8-bit, destination advances, software trigger
      set_ch(1, 24'h400055, 24'h600010, 16'd2, 16'd5, 4'hE);
      run_req(1, 1, "R5 R8 repeat 1");
      run_req(1, 1, "R5 R6 repeat wrap");
      run_req(1, 1, "R5 repeat after reload");

      // disabled codes discard requests
      set_ch(3, 24'hC00000, 24'hE00000, 16'd5, 16'd1, 4'h1);
      t0 = tr_n;
      pulse(4'h8);
      repeat (3) @(negedge clk);
      wr_reg(3, 4, 24'h000005);
      e_ctl[3] = 4'h5;
      wait_idle();
      chk_eq("R7 request while off dropped", tr_n - t0, 0);
      wr_reg(3, 4, 24'h000009);
      e_ctl[3] = 4'h9;
      run_req(3, 0, "R7 code 10 disabled");

      // priority with simultaneous requests
      for (int c = 0; c < NCH; c++)
         set_ch(c, 24'(c << 22), 24'(c << 22) | 24'h200000, 16'd20, 16'd0, 4'h5);
      t0 = tr_n;
      pulse(4'hF);
      wait_idle();
      chk_eq("R1 simultaneous count", tr_n - t0, 4);
      for (int k = 0; k < 4; k++) begin
         chk_eq("R1 service order", tr_src[t0 + k][23:22], k);
         apply_xfer(k);
      end

      // latched requests while another channel is on the bus
      t0 = tr_n;
      slow = 1;
      pulse(4'h8);
      wait_busy();
      pulse(4'h7);
      slow = 0;
      wait_idle();
      chk_eq("R8 latched count", tr_n - t0, 4);
      chk_eq("R8 first served", tr_src[t0][23:22], 3);
      for (int k = 1; k < 4; k++) chk_eq("R1 R8 latched order", tr_src[t0 + k][23:22], k - 1);
      for (int c = 0; c < NCH; c++) begin
         apply_xfer(c);
         check_regs(c, "R8 after latched");
      end

      // mode write during own transfer
      t0 = tr_n;
      slow = 1;
      pulse(4'h1);
      wait_busy();
      wr_reg(0, 4, 24'h000001);
      rd_reg(0, 4, v);
      chk_eq("R10 old mode mid transfer", v, 24'h5);
      chk_eq("R10 still on bus", bus_req, 1);
      slow = 0;
      wait_idle();
      chk_eq("R10 transfer completed", tr_n - t0, 1);
      apply_xfer(0);
      e_ctl[0] = 4'h1;
      check_regs(0, "R10 after transfer");
      run_req(0, 0, "R10 new mode off");

      // constrained random sequence
      for (int it = 0; it < 60; it++) begin
         int ch;
         logic [3:0] ctl;
         ch = int'($urandom_range(0, 3));
         if ($urandom_range(0, 2) == 0 || !e_elig(ch)) begin
            ctl = {2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))};
            set_ch(ch, 24'(ch << 22) | 24'($urandom_range(0, 20'hFFFFF)),
                   24'(ch << 22) | 24'h200000 | 24'($urandom_range(0, 20'hFFFFF)),
                   16'($urandom_range(0, 3)), 16'($urandom_range(0, 3)), ctl);
         end
         run_req(ch, bit'($urandom_range(0, 1)), "R3 R5 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule